// File: doc/BRIEF.md
# Multi-Requester Hardware Semaphore Bank

The block holds a bank of one-bit semaphores that several processors share through a plain 32-bit register bus. Each semaphore has its own word address. A processor takes a semaphore by reading its register. If the read returns zero, the semaphore was free, and the same access has already marked it as taken for that processor. If the read returns one, another agent holds it, and nothing changes. The holder gives the semaphore back by writing zero to the same register. So test-and-set is one bus access, and no other agent can get in between the test and the set.

Each requester has its own request port. When requests arrive in the same cycle, they are served in a fixed order, lowest port index first. The effect of each earlier port is visible to every later one. A read-only count register gives the number of semaphores as a multiple of 32, so software can size its tables. The bank size is a build parameter and may be 32, 64, 128 or 256.

Top module: `spl_bank_top`

## Requirements
- R1: After synchronous reset every semaphore is free, so the first read of any semaphore returns 0.
- R2: A read of a free semaphore returns 0 and leaves it taken, so the next read of it returns 1.
- R3: A read of a taken semaphore returns 1 (bits 31:1 zero) and leaves it taken.
- R4: A write of the value 0 to a semaphore register frees that semaphore.
- R5: A write of any nonzero value to a semaphore register leaves that semaphore's state unchanged.
- R6: Semaphore i (0 <= i < NUM_LOCKS) is at byte address 0x800 + 4*i. Address bits 1:0 must be zero.
- R7: A read of byte address 0x014 returns NUM_LOCKS/32 in bits 31:24 and zero in all other bits.
- R8: A read of any other address, including a semaphore index >= NUM_LOCKS or an address with bits 1:0 not zero, returns 0. A write to any such address changes no semaphore.
- R9: Requests in the same cycle are applied in ascending port order, and each port sees the result of the lower ports. When ports 0 and 1 both read the same free semaphore, port 0 gets 0 and port 1 gets 1.
- R10: For each read request, `bus_rvalid` is high, with the read data, exactly one cycle later. The semaphore update takes effect in that same clock edge. When `bus_rvalid` is low, `bus_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | NUM_PORTS | Per-port access request |
| bus_we | input | NUM_PORTS | Per-port write enable (0 = read) |
| bus_addr | input | NUM_PORTS*ADDR_W | Per-port byte address, port p in slice p |
| bus_wdata | input | NUM_PORTS*32 | Per-port write data |
| bus_rvalid | output | NUM_PORTS | Read data valid, one cycle after a read request |
| bus_rdata | output | NUM_PORTS*32 | Per-port registered read data |

## Verification
Every result is due on the clock edge that follows its request. This covers the read data, the valid flag and the new semaphore state. The bench drives a request on a falling edge and samples shortly after the next rising edge. It then compares the outputs with a reference model that it has already advanced through the ports in ascending order. The effect of a write cannot be seen directly at the outputs, so the bench checks it through a later read of the same semaphore. That read is due one cycle after its own request.

// File: rtl/spl_pkg.sv
package spl_pkg;

  localparam int SPL_DATA_W     = 32;
  localparam int SPL_STATUS_OFF = 'h014;
  localparam int SPL_LOCK_BASE  = 'h800;
  localparam int SPL_COUNT_LSB  = 24;
  localparam int SPL_GROUP      = 32;

  typedef enum logic [1:0] {
    SPL_UNMAPPED = 2'd0,
    SPL_STATUS   = 2'd1,
    SPL_LOCK     = 2'd2
  } spl_region_e;

  function automatic logic [SPL_DATA_W-1:0] spl_status_word(input int num_locks);
    logic [SPL_DATA_W-1:0] w;
    w = '0;
    w[SPL_COUNT_LSB +: 8] = 8'(num_locks / SPL_GROUP);
    return w;
  endfunction

endpackage

// File: rtl/spl_addr_decode.sv
module spl_addr_decode
  import spl_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_LOCKS = 32,
  localparam int LIDX_W   = $clog2(NUM_LOCKS)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output spl_region_e       region_o,
  output logic [LIDX_W-1:0] idx_o
);

  localparam logic [ADDR_W-1:0] STATUS_A = ADDR_W'(SPL_STATUS_OFF);
  localparam logic [ADDR_W-1:0] BASE_A   = ADDR_W'(SPL_LOCK_BASE);

  logic [ADDR_W-1:0] rel;
  logic              above_base;
  logic              in_window;

  always_comb begin
    rel        = addr_i - BASE_A;
    above_base = (addr_i >= BASE_A);
    in_window  = above_base && (rel[1:0] == 2'b00)
                 && (rel[ADDR_W-1:LIDX_W+2] == '0);
    idx_o      = rel[LIDX_W+1:2];
    if (addr_i == STATUS_A)
      region_o = SPL_STATUS;
    else if (in_window)
      region_o = SPL_LOCK;
    else
      region_o = SPL_UNMAPPED;
  end

endmodule

// File: rtl/spl_lock_core.sv
module spl_lock_core
  import spl_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int NUM_LOCKS = 32,
  localparam int LIDX_W   = $clog2(NUM_LOCKS)
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic [NUM_PORTS-1:0]                 req_i,
  input  logic [NUM_PORTS-1:0]                 we_i,
  input  logic [NUM_PORTS-1:0]                 wzero_i,
  input  spl_region_e                          region_i [NUM_PORTS],
  input  logic [NUM_PORTS-1:0][LIDX_W-1:0]     idx_i,
  output logic [NUM_PORTS-1:0][SPL_DATA_W-1:0] rdata_d_o,
  output logic [NUM_PORTS-1:0]                 rvalid_d_o,
  output logic [NUM_LOCKS-1:0]                 state_o
);

  localparam logic [SPL_DATA_W-1:0] STATUS_WORD = spl_status_word(NUM_LOCKS);

  logic [NUM_LOCKS-1:0] state_q;
  logic [NUM_LOCKS-1:0] state_n;

  // Ports are folded in ascending order; each sees the lower ports' effect.
  always_comb begin
    state_n   = state_q;
    rdata_d_o = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      rvalid_d_o[p] = req_i[p] && !we_i[p];
      if (req_i[p]) begin
        unique case (region_i[p])
          SPL_LOCK: begin
            if (!we_i[p]) begin
              rdata_d_o[p]          = {{(SPL_DATA_W-1){1'b0}}, state_n[idx_i[p]]};
              state_n[idx_i[p]]     = 1'b1;
            end else if (wzero_i[p]) begin
              state_n[idx_i[p]]     = 1'b0;
            end
          end
          SPL_STATUS: begin
            if (!we_i[p]) rdata_d_o[p] = STATUS_WORD;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= '0;
    else     state_q <= state_n;
  end

  assign state_o = state_q;

endmodule

// File: rtl/spl_resp_reg.sv
module spl_resp_reg
  import spl_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rvalid_d_i,
  input  logic [SPL_DATA_W-1:0] rdata_d_i,
  output logic                  rvalid_o,
  output logic [SPL_DATA_W-1:0] rdata_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rvalid_d_i;
      rdata_o  <= rvalid_d_i ? rdata_d_i : '0;
    end
  end

endmodule

// File: rtl/spl_bank_top.sv
module spl_bank_top
  import spl_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int NUM_LOCKS = 32,
  parameter int ADDR_W    = 12
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_PORTS-1:0]            bus_req,
  input  logic [NUM_PORTS-1:0]            bus_we,
  input  logic [NUM_PORTS*ADDR_W-1:0]     bus_addr,
  input  logic [NUM_PORTS*SPL_DATA_W-1:0] bus_wdata,
  output logic [NUM_PORTS-1:0]            bus_rvalid,
  output logic [NUM_PORTS*SPL_DATA_W-1:0] bus_rdata
);

  localparam int LIDX_W = $clog2(NUM_LOCKS);

  spl_region_e                          region   [NUM_PORTS];
  logic [NUM_PORTS-1:0][LIDX_W-1:0]     idx;
  logic [NUM_PORTS-1:0]                 wzero;
  logic [NUM_PORTS-1:0][SPL_DATA_W-1:0] rdata_d;
  logic [NUM_PORTS-1:0]                 rvalid_d;
  logic [NUM_LOCKS-1:0]                 lock_state;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    spl_addr_decode #(
      .ADDR_W   (ADDR_W),
      .NUM_LOCKS(NUM_LOCKS)
    ) dec_i (
      .addr_i  (bus_addr[p*ADDR_W +: ADDR_W]),
      .region_o(region[p]),
      .idx_o   (idx[p])
    );

    assign wzero[p] = (bus_wdata[p*SPL_DATA_W +: SPL_DATA_W] == '0);

    spl_resp_reg resp_i (
      .clk       (clk),
      .rst       (rst),
      .rvalid_d_i(rvalid_d[p]),
      .rdata_d_i (rdata_d[p]),
      .rvalid_o  (bus_rvalid[p]),
      .rdata_o   (bus_rdata[p*SPL_DATA_W +: SPL_DATA_W])
    );
  end

  spl_lock_core #(
    .NUM_PORTS(NUM_PORTS),
    .NUM_LOCKS(NUM_LOCKS)
  ) core_i (
    .clk       (clk),
    .rst       (rst),
    .req_i     (bus_req),
    .we_i      (bus_we),
    .wzero_i   (wzero),
    .region_i  (region),
    .idx_i     (idx),
    .rdata_d_o (rdata_d),
    .rvalid_d_o(rvalid_d),
    .state_o   (lock_state)
  );

endmodule

// File: rtl/spl_bank_checker.sv
module spl_bank_checker #(
  parameter int NUM_PORTS = 2,
  parameter int NUM_LOCKS = 32,
  parameter int ADDR_W    = 12
) (
  input logic                    clk,
  input logic                    rst,
  input logic [NUM_PORTS-1:0]    bus_req,
  input logic [NUM_PORTS-1:0]    bus_we,
  input logic [NUM_PORTS*ADDR_W-1:0] bus_addr,
  input logic [NUM_PORTS*32-1:0] bus_wdata,
  input logic [NUM_PORTS-1:0]    bus_rvalid,
  input logic [NUM_PORTS*32-1:0] bus_rdata,
  input logic [NUM_LOCKS-1:0]    lock_state
);

  localparam logic [31:0] EXP_STATUS = 32'(NUM_LOCKS / 32) << 24;

  logic [NUM_PORTS-1:0] c_rd;
  logic [NUM_PORTS-1:0] c_lock;
  logic [NUM_PORTS-1:0] c_stat;
  int                   c_idx [NUM_PORTS];
  logic                 any_zero_wr;
  logic                 any_lock_rd;

  always_comb begin
    any_zero_wr = 1'b0;
    any_lock_rd = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      logic [ADDR_W-1:0] a;
      a         = bus_addr[p*ADDR_W +: ADDR_W];
      c_rd[p]   = bus_req[p] && !bus_we[p];
      c_idx[p]  = (int'(a) - 'h800) / 4;
      c_lock[p] = (a[1:0] == 2'b00) && (int'(a) >= 'h800)
                  && (int'(a) < 'h800 + 4 * NUM_LOCKS);
      c_stat[p] = (int'(a) == 'h014);
      if (bus_req[p] && bus_we[p] && c_lock[p]
          && bus_wdata[p*32 +: 32] == 32'd0) any_zero_wr = 1'b1;
      if (c_rd[p] && c_lock[p]) any_lock_rd = 1'b1;
    end
  end

  AST_RESET_FREE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> lock_state == '0); // R1

  AST_NO_CLEAR_WITHOUT_ZERO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !any_zero_wr |=> (lock_state & $past(lock_state)) == $past(lock_state)); // R5

  AST_NO_SET_WITHOUT_LOCK_READ: assert property (@(posedge clk) disable iff (rst)
    !any_lock_rd |=> (lock_state & ~$past(lock_state)) == '0); // R8

  AST_SINGLE_WINNER: assert property (@(posedge clk) disable iff (rst)
    (c_rd[0] && c_rd[1] && c_lock[0] && c_lock[1] && c_idx[0] == c_idx[1])
    |=> !(bus_rdata[31:0] == 32'd0 && bus_rdata[63:32] == 32'd0)); // R9

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
    AST_RVALID_ON_READ: assert property (@(posedge clk) disable iff (rst)
      c_rd[p] |=> bus_rvalid[p]); // R10

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
      !c_rd[p] |=> !bus_rvalid[p] && bus_rdata[p*32 +: 32] == 32'd0); // R10

    AST_ACQUIRE_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (c_rd[p] && c_lock[p] && !any_zero_wr) |=> lock_state[$past(c_idx[p])]); // R2

    AST_LOCK_DATA_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
      (c_rd[p] && c_lock[p]) |=> bus_rdata[p*32+1 +: 31] == 31'd0); // R3

    AST_STATUS_WORD: assert property (@(posedge clk) disable iff (rst)
      (c_rd[p] && c_stat[p]) |=> bus_rdata[p*32 +: 32] == EXP_STATUS); // R7

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
      (c_rd[p] && !c_lock[p] && !c_stat[p]) |=> bus_rdata[p*32 +: 32] == 32'd0); // R8
  end

endmodule

bind spl_bank_top spl_bank_checker #(
  .NUM_PORTS(NUM_PORTS),
  .NUM_LOCKS(NUM_LOCKS),
  .ADDR_W   (ADDR_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .bus_req   (bus_req),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rvalid(bus_rvalid),
  .bus_rdata (bus_rdata),
  .lock_state(lock_state)
);

// File: tb/spl_bank_top_tb_top.sv
module spl_bank_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NP         = 2;
  localparam int NL         = 64;
  localparam int AW         = 12;
  localparam logic [31:0] STATUS_EXP = 32'h0200_0000;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [NP-1:0]    req = '0;
  logic [NP-1:0]    we  = '0;
  logic [NP*AW-1:0] addr  = '0;
  logic [NP*32-1:0] wdata = '0;
  logic [NP-1:0]    rvalid;
  logic [NP*32-1:0] rdata;

  int checks   = 0;
  int failures = 0;
  bit model [NL];

  always #(CLK_PERIOD/2) clk = ~clk;

  spl_bank_top #(.NUM_PORTS(NP), .NUM_LOCKS(NL), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .bus_req(req), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rvalid(rvalid), .bus_rdata(rdata)
  );

  function automatic logic [AW-1:0] lk(input int i);
    return AW'('h800 + 4 * i);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one cycle on both ports; model applies ports in ascending order.
  task automatic step(input string tag,
                      input logic r0, input logic w0, input logic [AW-1:0] a0, input logic [31:0] d0,
                      input logic r1, input logic w1, input logic [AW-1:0] a1, input logic [31:0] d1);
    logic        rr [NP];
    logic        ww [NP];
    logic [AW-1:0] aa [NP];
    logic [31:0] dd [NP];
    logic [31:0] exp_d [NP];
    logic        exp_v [NP];
    rr[0] = r0; ww[0] = w0; aa[0] = a0; dd[0] = d0;
    rr[1] = r1; ww[1] = w1; aa[1] = a1; dd[1] = d1;
    @(negedge clk);
    req   = {r1, r0};
    we    = {w1, w0};
    addr  = {a1, a0};
    wdata = {d1, d0};
    for (int p = 0; p < NP; p++) begin
      int  ai;
      int  li;
      bit  is_lock;
      ai      = int'(aa[p]);
      li      = (ai - 'h800) / 4;
      is_lock = (ai % 4 == 0) && ai >= 'h800 && ai < 'h800 + 4 * NL;
      exp_v[p] = rr[p] && !ww[p];
      exp_d[p] = 32'd0;
      if (rr[p]) begin
        if (is_lock) begin
          if (!ww[p]) begin
            exp_d[p] = {31'd0, model[li]};
            model[li] = 1'b1;
          end else if (dd[p] == 32'd0) begin
            model[li] = 1'b0;
          end
        end else if (ai == 'h014 && !ww[p]) begin
          exp_d[p] = STATUS_EXP;
        end
      end
    end
    @(posedge clk);
    #1;
    for (int p = 0; p < NP; p++) begin
      check($sformatf("%s p%0d rvalid", tag, p), {31'd0, rvalid[p]}, {31'd0, exp_v[p]});
      check($sformatf("%s p%0d rdata", tag, p), rdata[p*32 +: 32], exp_d[p]);
    end
    req = '0; we = '0;
  endtask

  task automatic rd0(input string tag, input logic [AW-1:0] a);
    step(tag, 1'b1, 1'b0, a, 32'd0, 1'b0, 1'b0, '0, 32'd0);
  endtask

  task automatic wr0(input string tag, input logic [AW-1:0] a, input logic [31:0] d);
    step(tag, 1'b1, 1'b1, a, d, 1'b0, 1'b0, '0, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    for (int i = 0; i < NL; i++) model[i] = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R10 reset rvalid", {30'd0, rvalid}, 32'd0);
    check("R10 reset rdata lo", rdata[31:0], 32'd0);
    @(negedge clk);
    rst = 1'b0;

    // R1: every lock free after reset (reading also acquires it)
    for (int i = 0; i < NL; i++) rd0("R1 first read", lk(i));
    // R4: release all
    for (int i = 0; i < NL; i++) wr0("R4 release", lk(i), 32'd0);

    rd0("R2 acquire lock 5", lk(5));
    rd0("R3 lock 5 taken", lk(5));
    wr0("R5 nonzero write", lk(5), 32'hFFFF_FFFF);
    rd0("R5 still taken", lk(5));
    wr0("R4 zero write", lk(5), 32'd0);
    rd0("R4 free again", lk(5));

    // R6 boundary: top lock, then index just past the end, unaligned
    rd0("R6 last lock", lk(NL - 1));
    rd0("R6 last lock taken", lk(NL - 1));
    rd0("R8 index past end", lk(NL));
    rd0("R8 index past end again", lk(NL));
    wr0("R8 zero write past end", lk(NL), 32'd0);
    rd0("R8 lock 0 unaffected", lk(0));
    rd0("R8 lock 0 still taken", lk(0));
    rd0("R8 unaligned", AW'('h805));
    wr0("R8 zero write unaligned", AW'('h801), 32'd0);
    rd0("R8 lock 0 after unaligned", lk(0));
    rd0("R7 status", AW'('h014));
    wr0("R7 status write", AW'('h014), 32'd0);
    rd0("R7 status again", AW'('h014));

    // R9 same-cycle contention
    step("R9 both read free", 1'b1, 1'b0, lk(9), 32'd0, 1'b1, 1'b0, lk(9), 32'd0);
    step("R9 p0 release p1 read", 1'b1, 1'b1, lk(9), 32'd0, 1'b1, 1'b0, lk(9), 32'd0);
    step("R9 p0 read p1 release", 1'b1, 1'b0, lk(9), 32'd0, 1'b1, 1'b1, lk(9), 32'd0);
    rd0("R9 after ordered release", lk(9));

    // Random mix over a narrow address set to force collisions
    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] a [NP];
      logic          r [NP];
      logic          w [NP];
      logic [31:0]   d [NP];
      for (int p = 0; p < NP; p++) begin
        int sel;
        sel  = int'($urandom_range(0, 19));
        if (sel < 14)       a[p] = lk(int'($urandom_range(0, 5)) + ((sel & 1) != 0 ? NL - 3 : 0));
        else if (sel < 16)  a[p] = AW'('h014);
        else if (sel < 18)  a[p] = lk(NL + int'($urandom_range(0, 3)));
        else                a[p] = AW'($urandom_range(0, 'hFFF));
        r[p] = ($urandom_range(0, 3) != 0);
        w[p] = ($urandom_range(0, 2) == 0);
        d[p] = ($urandom_range(0, 4) < 3) ? 32'd0 : $urandom;
      end
      step("R9 random", r[0], w[0], a[0], d[0], r[1], w[1], a[1], d[1]);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule